// File: doc/BRIEF.md
# Speculative Cache Line State Tracker

This block keeps the speculation bookkeeping for each line of a small direct-mapped data cache used in a processor that runs threads speculatively. For every line it holds a valid bit, a stored tag, a modified bit, a pending-invalidate bit, and two bits per data word: one marking that the local thread loaded the word while speculative, one marking that it stored to it. The word data, refill machinery and replacement policy live elsewhere. A fill port only installs a tag and marks the line valid.

The local processor presents loads and stores on one port. A snoop port watches stores broadcast by other processors. A broadcast from a less speculative thread that lands on a word this thread has already read, without having written it first, is a read-after-write hazard. It raises a sticky violation flag and records the address. Two command inputs end a speculative phase. A commit keeps the speculative work and applies the deferred invalidations. A backup discards the speculative work. Each command updates every line in a single clock.

Addresses are word addresses. The low `log2(WORDS)` bits select the word, the next `log2(LINES)` bits select the line, and the remaining upper bits form the tag.

Top module: `spec_tag_array`

## Requirements
- R1: While `rst` is high at a clock edge, all lines become invalid and unmodified, and the violation flag and address clear. Both are visible after that edge.
- R2: `fill_en` makes the indexed line valid with the address tag and clears that line's modified, pending-invalidate and per-word bits. `line_valid` shows the change one cycle later.
- R3: A load (`loc_en`=1, `loc_store`=0) hits when the indexed line is valid and its tag matches. It sets the word's read bit only while `spec_on` is 1. A non-speculative load or a miss leaves all state unchanged.
- R4: A speculative store hit sets the word's written bit and the line's modified bit. A line that is marked modified is always valid.
- R5: A snoop with `snp_older`=1 that hits a valid line, where the addressed word has its read bit set and its written bit clear, sets `viol_flag` on the next cycle with `viol_addr` equal to `snp_addr`. A snoop that misses never raises the flag.
- R6: A snoop with `snp_older`=0, or one aimed at a word whose written bit is set, raises no violation. Any snoop hit sets the line's pending-invalidate bit and leaves the line valid.
- R7: Once set, `viol_flag` stays set and `viol_addr` keeps the first offending address until a commit or backup clears both.
- R8: Commit (`cmd_commit`=1, `cmd_backup`=0) clears every read, written and modified bit in one cycle. It invalidates every line whose pending-invalidate bit is set, then clears those bits.
- R9: Backup (`cmd_backup`=1) clears every read, written and modified bit in one cycle and invalidates every line that was modified. Pending-invalidate bits survive a backup.
- R10: Backup wins over commit when both are high. In a command cycle the fill, local and snoop inputs are ignored. A fill overrides a local access or snoop aimed at the same line in the same cycle.
- R11: A speculative load of a word that already has its written bit set leaves the read bit clear, so a later older snoop to it raises no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spec_on | input | 1 | Local thread is running speculatively |
| cmd_commit | input | 1 | Gang commit command |
| cmd_backup | input | 1 | Gang backup command |
| fill_en | input | 1 | Install a line |
| fill_addr | input | ADDR_W | Word address of the line being installed |
| loc_en | input | 1 | Local access valid |
| loc_store | input | 1 | Local access is a store (0 = load) |
| loc_addr | input | ADDR_W | Local access word address |
| snp_en | input | 1 | Snooped broadcast store valid |
| snp_older | input | 1 | Broadcast comes from a less speculative thread |
| snp_addr | input | ADDR_W | Snooped word address |
| viol_flag | output | 1 | Sticky read-after-write violation |
| viol_addr | output | ADDR_W | First address that caused a violation |
| line_valid | output | LINES | Per-line valid state |
| line_mod | output | LINES | Per-line modified state |

## Verification
Some properties are checked by assertions on every cycle: the reset state, the stickiness of the flag and its address, the rule that a modified line is valid, the fact that a violation follows only an older snoop, and the effect of the gang commands on the valid and modified vectors. Per-word rules need a specific ordering of loads, stores and snoops before they show at the ports. These are the rules that a self-written word suppresses both the read mark and the hazard, that a younger snoop is harmless, and that pending invalidations survive a backup but not a commit. Same-cycle priority is in the same position. These rules are shown only by the bench's directed sequences and its random traffic compared against a reference model.

// File: rtl/spec_tag_pkg.sv
package spec_tag_pkg;

  typedef enum logic [1:0] {
    GANG_NONE   = 2'd0,
    GANG_COMMIT = 2'd1,
    GANG_BACKUP = 2'd2
  } gang_e;

  // Backup dominates commit when both are requested together.
  function automatic gang_e gang_pick(input logic commit, input logic backup);
    if (backup)      return GANG_BACKUP;
    else if (commit) return GANG_COMMIT;
    else             return GANG_NONE;
  endfunction

endpackage

// File: rtl/spec_tag_store.sv
// Tag storage: written only by fills, read asynchronously by NPORT lookups.
module spec_tag_store #(
  parameter int LINES = 8,
  parameter int IDX_W = 3,
  parameter int TAG_W = 7,
  parameter int NPORT = 2
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic [NPORT-1:0][IDX_W-1:0] q_idx,
  input  logic [NPORT-1:0][TAG_W-1:0] q_tag,
  output logic [NPORT-1:0]           q_match
);

  logic [TAG_W-1:0] tag_mem [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign q_match[p] = (tag_mem[q_idx[p]] == q_tag[p]);
  end

endmodule

// File: rtl/spec_line_state.sv
// Per-line speculation flops with single-cycle gang updates.
module spec_line_state
  import spec_tag_pkg::*;
#(
  parameter int LINES = 8,
  parameter int WORDS = 4,
  parameter int IDX_W = 3,
  parameter int OFS_W = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  gang_e                        gang,
  input  logic                         fill_go,
  input  logic [IDX_W-1:0]             fill_idx,
  input  logic                         mark_rd,
  input  logic                         mark_wr,
  input  logic [IDX_W-1:0]             loc_idx,
  input  logic [OFS_W-1:0]             loc_ofs,
  input  logic                         mark_pend,
  input  logic [IDX_W-1:0]             snp_idx,
  output logic [LINES-1:0]             valid_o,
  output logic [LINES-1:0]             mod_o,
  output logic [LINES-1:0][WORDS-1:0]  rd_o,
  output logic [LINES-1:0][WORDS-1:0]  wr_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic             v_r;
    logic             m_r;
    logic             p_r;
    logic [WORDS-1:0] rd_r;
    logic [WORDS-1:0] wr_r;
    logic             sel_fill;
    logic             sel_loc;
    logic             sel_snp;

    assign sel_fill = fill_go && (fill_idx == IDX_W'(g));
    assign sel_loc  = (loc_idx == IDX_W'(g));
    assign sel_snp  = (snp_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        v_r  <= 1'b0;
        m_r  <= 1'b0;
        p_r  <= 1'b0;
        rd_r <= '0;
        wr_r <= '0;
      end else begin
        unique case (gang)
          GANG_BACKUP: begin
            rd_r <= '0;
            wr_r <= '0;
            m_r  <= 1'b0;
            if (m_r) v_r <= 1'b0;
          end
          GANG_COMMIT: begin
            rd_r <= '0;
            wr_r <= '0;
            m_r  <= 1'b0;
            p_r  <= 1'b0;
            if (p_r) v_r <= 1'b0;
          end
          default: begin
            if (sel_fill) begin
              v_r  <= 1'b1;
              m_r  <= 1'b0;
              p_r  <= 1'b0;
              rd_r <= '0;
              wr_r <= '0;
            end else begin
              if (mark_rd && sel_loc) rd_r[loc_ofs] <= 1'b1;
              if (mark_wr && sel_loc) begin
                wr_r[loc_ofs] <= 1'b1;
                m_r           <= 1'b1;
              end
              if (mark_pend && sel_snp) p_r <= 1'b1;
            end
          end
        endcase
      end
    end

    assign valid_o[g] = v_r;
    assign mod_o[g]   = m_r;
    assign rd_o[g]    = rd_r;
    assign wr_o[g]    = wr_r;
  end

endmodule

// File: rtl/spec_viol_unit.sv
// Sticky hazard capture: keeps the first offending address.
module spec_viol_unit #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              detect,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              flag_q,
  output logic [ADDR_W-1:0] addr_q
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      flag_q <= 1'b0;
      addr_q <= '0;
    end else if (detect && !flag_q) begin
      flag_q <= 1'b1;
      addr_q <= addr_in;
    end
  end

endmodule

// File: rtl/spec_tag_array.sv
module spec_tag_array
  import spec_tag_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spec_on,
  input  logic              cmd_commit,
  input  logic              cmd_backup,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              loc_en,
  input  logic              loc_store,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic              snp_en,
  input  logic              snp_older,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              viol_flag,
  output logic [ADDR_W-1:0] viol_addr,
  output logic [LINES-1:0]  line_valid,
  output logic [LINES-1:0]  line_mod
);

  localparam int OFS_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;
  localparam int TAG_LO = OFS_W + IDX_W;

  gang_e gang;
  logic  busy;

  logic [OFS_W-1:0] loc_ofs, snp_ofs;
  logic [IDX_W-1:0] loc_idx, snp_idx, fill_idx;
  logic [TAG_W-1:0] loc_tag, snp_tag, fill_tag;

  logic [1:0]                     tag_match;
  logic [LINES-1:0][WORDS-1:0]    rd_bits, wr_bits;

  logic loc_hit, snp_hit, fill_go;
  logic fill_on_loc, fill_on_snp;
  logic mark_rd, mark_wr, mark_pend, hazard;
  logic snp_word_rd, snp_word_wr, loc_word_wr;

  assign gang = gang_pick(cmd_commit, cmd_backup);
  assign busy = (gang != GANG_NONE);

  assign loc_ofs  = loc_addr[OFS_W-1:0];
  assign loc_idx  = loc_addr[TAG_LO-1:OFS_W];
  assign loc_tag  = loc_addr[ADDR_W-1:TAG_LO];
  assign snp_ofs  = snp_addr[OFS_W-1:0];
  assign snp_idx  = snp_addr[TAG_LO-1:OFS_W];
  assign snp_tag  = snp_addr[ADDR_W-1:TAG_LO];
  assign fill_idx = fill_addr[TAG_LO-1:OFS_W];
  assign fill_tag = fill_addr[ADDR_W-1:TAG_LO];

  assign fill_go = fill_en && !busy;

  spec_tag_store #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .NPORT(2)
  ) u_tags (
    .clk     (clk),
    .wr_en   (fill_go),
    .wr_idx  (fill_idx),
    .wr_tag  (fill_tag),
    .q_idx   ({snp_idx, loc_idx}),
    .q_tag   ({snp_tag, loc_tag}),
    .q_match (tag_match)
  );

  assign loc_hit     = line_valid[loc_idx] && tag_match[0];
  assign snp_hit     = line_valid[snp_idx] && tag_match[1];
  assign fill_on_loc = fill_go && (fill_idx == loc_idx);
  assign fill_on_snp = fill_go && (fill_idx == snp_idx);
  assign loc_word_wr = wr_bits[loc_idx][loc_ofs];
  assign snp_word_rd = rd_bits[snp_idx][snp_ofs];
  assign snp_word_wr = wr_bits[snp_idx][snp_ofs];

  always_comb begin
    mark_rd   = 1'b0;
    mark_wr   = 1'b0;
    mark_pend = 1'b0;
    hazard    = 1'b0;
    if (!busy) begin
      if (loc_en && spec_on && loc_hit && !fill_on_loc) begin
        if (loc_store)         mark_wr = 1'b1;
        else if (!loc_word_wr) mark_rd = 1'b1;
      end
      if (snp_en && snp_hit && !fill_on_snp) begin
        mark_pend = 1'b1;
        hazard    = snp_older && snp_word_rd && !snp_word_wr;
      end
    end
  end

  spec_line_state #(
    .LINES(LINES), .WORDS(WORDS), .IDX_W(IDX_W), .OFS_W(OFS_W)
  ) u_state (
    .clk       (clk),
    .rst       (rst),
    .gang      (gang),
    .fill_go   (fill_go),
    .fill_idx  (fill_idx),
    .mark_rd   (mark_rd),
    .mark_wr   (mark_wr),
    .loc_idx   (loc_idx),
    .loc_ofs   (loc_ofs),
    .mark_pend (mark_pend),
    .snp_idx   (snp_idx),
    .valid_o   (line_valid),
    .mod_o     (line_mod),
    .rd_o      (rd_bits),
    .wr_o      (wr_bits)
  );

  spec_viol_unit #(.ADDR_W(ADDR_W)) u_viol (
    .clk     (clk),
    .rst     (rst),
    .clear   (busy),
    .detect  (hazard),
    .addr_in (snp_addr),
    .flag_q  (viol_flag),
    .addr_q  (viol_addr)
  );

endmodule

// File: rtl/spec_tag_array_chk.sv
module spec_tag_array_chk #(
  parameter int LINES  = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_commit,
  input logic              cmd_backup,
  input logic              snp_en,
  input logic              snp_older,
  input logic              viol_flag,
  input logic [ADDR_W-1:0] viol_addr,
  input logic [LINES-1:0]  line_valid,
  input logic [LINES-1:0]  line_mod
);

  assert_reset_clean_R1: assert property (@(posedge clk)
    rst |=> (line_valid == '0 && line_mod == '0 && !viol_flag));

  assert_mod_implies_valid_R4: assert property (@(posedge clk) disable iff (rst)
    (line_mod & ~line_valid) == '0);

  assert_viol_from_older_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(viol_flag) |-> $past(snp_en && snp_older));

  assert_viol_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (viol_flag && !cmd_commit && !cmd_backup) |=> (viol_flag && $stable(viol_addr)));

  assert_commit_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_commit && !cmd_backup) |=> (line_mod == '0 && !viol_flag));

  assert_backup_drops_mod_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_backup |=> (line_mod == '0 && (line_valid & $past(line_mod)) == '0 && !viol_flag));

  assert_cmd_blocks_fill_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_commit || cmd_backup) |=> ((line_valid & ~$past(line_valid)) == '0));

endmodule

bind spec_tag_array spec_tag_array_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_commit (cmd_commit),
  .cmd_backup (cmd_backup),
  .snp_en     (snp_en),
  .snp_older  (snp_older),
  .viol_flag  (viol_flag),
  .viol_addr  (viol_addr),
  .line_valid (line_valid),
  .line_mod   (line_mod)
);

// File: tb/tb_spec_tag_array.sv
module tb_spec_tag_array;

  localparam int CLK_P  = 10;
  localparam int LINES  = 8;
  localparam int WORDS  = 4;
  localparam int ADDR_W = 12;
  localparam int OFS_W  = 2;
  localparam int IDX_W  = 3;
  localparam int TAG_W  = ADDR_W - IDX_W - OFS_W;

  logic clk = 1'b0;
  logic rst, spec_on, cmd_commit, cmd_backup, fill_en, loc_en, loc_store, snp_en, snp_older;
  logic [ADDR_W-1:0] fill_addr, loc_addr, snp_addr;
  logic viol_flag;
  logic [ADDR_W-1:0] viol_addr;
  logic [LINES-1:0] line_valid, line_mod;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;

  spec_tag_array #(.LINES(LINES), .WORDS(WORDS), .ADDR_W(ADDR_W)) dut (.*);

  // reference model state
  logic             m_val [LINES];
  logic [TAG_W-1:0] m_tag [LINES];
  logic             m_mod [LINES];
  logic             m_pre [LINES];
  logic [WORDS-1:0] m_rd  [LINES];
  logic [WORDS-1:0] m_wr  [LINES];
  logic             m_vf;
  logic [ADDR_W-1:0] m_va;

  function automatic logic [ADDR_W-1:0] mk(input int t, input int i, input int o);
    return {TAG_W'(t), IDX_W'(i), OFS_W'(o)};
  endfunction

  function automatic logic [LINES-1:0] m_valid_vec();
    logic [LINES-1:0] v;
    for (int i = 0; i < LINES; i++) v[i] = m_val[i];
    return v;
  endfunction

  function automatic logic [LINES-1:0] m_mod_vec();
    logic [LINES-1:0] v;
    for (int i = 0; i < LINES; i++) v[i] = m_mod[i];
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_step();
    int li, lo, si, so, fi;
    logic lh, sh, fl, fs, det;
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        m_val[i] = 0; m_mod[i] = 0; m_pre[i] = 0; m_rd[i] = 0; m_wr[i] = 0;
      end
      m_vf = 0; m_va = 0;
    end else if (cmd_backup || cmd_commit) begin
      for (int i = 0; i < LINES; i++) begin
        if (cmd_backup) begin
          if (m_mod[i]) m_val[i] = 0;
        end else begin
          if (m_pre[i]) m_val[i] = 0;
          m_pre[i] = 0;
        end
        m_mod[i] = 0; m_rd[i] = 0; m_wr[i] = 0;
      end
      m_vf = 0; m_va = 0;
    end else begin
      lo = int'(loc_addr[OFS_W-1:0]);  li = int'(loc_addr[OFS_W+IDX_W-1:OFS_W]);
      so = int'(snp_addr[OFS_W-1:0]);  si = int'(snp_addr[OFS_W+IDX_W-1:OFS_W]);
      fi = int'(fill_addr[OFS_W+IDX_W-1:OFS_W]);
      lh = m_val[li] && m_tag[li] == loc_addr[ADDR_W-1:OFS_W+IDX_W];
      sh = m_val[si] && m_tag[si] == snp_addr[ADDR_W-1:OFS_W+IDX_W];
      fl = fill_en && fi == li;
      fs = fill_en && fi == si;
      det = snp_en && snp_older && sh && m_rd[si][so] && !m_wr[si][so] && !fs;
      if (det && !m_vf) begin m_vf = 1; m_va = snp_addr; end
      if (loc_en && spec_on && lh && !fl) begin
        if (loc_store) begin m_wr[li][lo] = 1; m_mod[li] = 1; end
        else if (!m_wr[li][lo]) m_rd[li][lo] = 1;
      end
      if (snp_en && sh && !fs) m_pre[si] = 1;
      if (fill_en) begin
        m_val[fi] = 1; m_tag[fi] = fill_addr[ADDR_W-1:OFS_W+IDX_W];
        m_mod[fi] = 0; m_pre[fi] = 0; m_rd[fi] = 0; m_wr[fi] = 0;
      end
    end
  endtask

  task automatic idle();
    cmd_commit = 0; cmd_backup = 0; fill_en = 0; loc_en = 0; loc_store = 0;
    snp_en = 0; snp_older = 0; fill_addr = 0; loc_addr = 0; snp_addr = 0;
  endtask

  // advance one cycle, update the model, compare all outputs after the edge
  task automatic tick(input bit cmp);
    @(posedge clk);
    m_step();
    @(negedge clk);
    if (cmp) begin
      chk("R2 valid", 32'(line_valid), 32'(m_valid_vec()));
      chk("R4 mod", 32'(line_mod), 32'(m_mod_vec()));
      chk("R5 flag", 32'(viol_flag), 32'(m_vf));
      chk("R7 addr", 32'(viol_addr), 32'(m_va));
    end
    idle();
  endtask

  task automatic do_fill(input logic [ADDR_W-1:0] a);
    fill_en = 1; fill_addr = a; tick(1);
  endtask
  task automatic do_loc(input logic st, input logic [ADDR_W-1:0] a);
    loc_en = 1; loc_store = st; loc_addr = a; tick(1);
  endtask
  task automatic do_snp(input logic older, input logic [ADDR_W-1:0] a);
    snp_en = 1; snp_older = older; snp_addr = a; tick(1);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd7);
    idle(); spec_on = 1; rst = 1;
    for (int i = 0; i < LINES; i++) m_tag[i] = 0;
    @(negedge clk);
    tick(0); tick(0); tick(0);
    rst = 0;
    chk("R1 valid", 32'(line_valid), 0);
    chk("R1 mod", 32'(line_mod), 0);
    chk("R1 flag", 32'(viol_flag), 0);

    // R2 fill
    do_fill(mk(3,1,0));
    chk("R2", 32'(line_valid), 32'h02);
    // R3/R5 load then older snoop
    do_loc(0, mk(3,1,2));
    do_snp(1, mk(3,1,2));
    chk("R5 flag", 32'(viol_flag), 1);
    chk("R5 addr", 32'(viol_addr), 32'(mk(3,1,2)));
    // R7 second hazard keeps first address
    do_loc(0, mk(3,1,3));
    do_snp(1, mk(3,1,3));
    chk("R7", 32'(viol_addr), 32'(mk(3,1,2)));
    // R4 store marks modified
    do_loc(1, mk(3,1,0));
    chk("R4", 32'(line_mod), 32'h02);
    // R9 backup drops modified line
    cmd_backup = 1; tick(1);
    chk("R9 valid", 32'(line_valid), 0);
    chk("R7 cleared", 32'(viol_flag), 0);

    // R11 / R6
    do_fill(mk(5,2,0));
    do_loc(1, mk(5,2,1));
    do_loc(0, mk(5,2,1));
    do_snp(1, mk(5,2,1));
    chk("R11", 32'(viol_flag), 0);
    do_loc(0, mk(5,2,3));
    do_snp(0, mk(5,2,3));
    chk("R6 younger", 32'(viol_flag), 0);
    chk("R6 still valid", 32'(line_valid), 32'h04);
    do_snp(1, mk(4,2,3));
    chk("R5 miss", 32'(viol_flag), 0);
    do_snp(1, mk(5,2,3));
    chk("R5 hit", 32'(viol_flag), 1);
    cmd_commit = 1; tick(1);
    chk("R8 valid", 32'(line_valid), 0);
    chk("R8 flag", 32'(viol_flag), 0);

    // R3 non-speculative load sets nothing
    do_fill(mk(1,3,0));
    spec_on = 0; do_loc(0, mk(1,3,0)); spec_on = 1;
    do_snp(1, mk(1,3,0));
    chk("R3", 32'(viol_flag), 0);
    cmd_backup = 1; tick(1);
    chk("R9 pending kept", 32'(line_valid), 32'h08);
    cmd_commit = 1; tick(1);
    chk("R8 pending applied", 32'(line_valid), 0);

    // R10 priorities
    do_fill(mk(2,4,0));
    do_fill(mk(2,5,0));
    do_loc(1, mk(2,4,0));
    do_snp(0, mk(2,5,1));
    cmd_commit = 1; cmd_backup = 1; fill_en = 1; fill_addr = mk(2,6,0); tick(1);
    chk("R10 backup wins", 32'(line_valid), 32'h20);
    fill_en = 1; fill_addr = mk(2,5,0); loc_en = 1; loc_store = 1; loc_addr = mk(2,5,0); tick(1);
    chk("R10 fill wins", 32'(line_mod), 0);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      spec_on    = ($urandom_range(0, 9) != 0);
      cmd_backup = (r < 2);
      cmd_commit = (r >= 2 && r < 5);
      fill_en    = ($urandom_range(0, 5) == 0);
      fill_addr  = mk($urandom_range(0,1), $urandom_range(0,7), $urandom_range(0,3));
      loc_en     = ($urandom_range(0, 1) == 0);
      loc_store  = ($urandom_range(0, 2) == 0);
      loc_addr   = mk($urandom_range(0,1), $urandom_range(0,7), $urandom_range(0,3));
      snp_en     = ($urandom_range(0, 2) == 0);
      snp_older  = ($urandom_range(0, 3) != 0);
      snp_addr   = mk($urandom_range(0,1), $urandom_range(0,7), $urandom_range(0,3));
      tick(1);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule